// File: doc/BRIEF.md
# LPC and Firmware-Hub Address Decoder

This block decides, for every host cycle, whether the cycle belongs on the low-pin-count side bus. It holds two enable registers, which the configuration port writes and reads back. The first is a 16-bit I/O enable word, with one bit for each legacy port group. The second is an 8-bit firmware-hub enable byte, which opens windows near the top of the 32-bit memory space.

An I/O cycle is matched on the low 16 address bits against thirteen fixed port windows. A memory cycle is matched against the firmware-hub windows and their register-space aliases, which sit 4 MB lower. It is also matched against a low-memory shadow of the top 128 KB. A shadow hit comes out with the translated high address, so the downstream bus only ever sees the real flash location.

The firmware-hub byte takes its starting value from a board strap, which is sampled when power-good rises. All decode outputs are combinational. A register write changes the decode from the next clock edge on.

Top module: `lpc_fwh_decoder`

## Requirements
- R1: After reset, the I/O enable word reads 0000h, the firmware-hub byte reads 00h, and no cycle is forwarded.
- R2: Bits 15:13 of the I/O enable word ignore writes and always read as zero. Writing FFFFh reads back 1FFFh.
- R3: On the first clock at which `pwr_good` is seen high after being low, the firmware-hub byte loads a value from `strap_in`. A strap of 1 loads 00h and a strap of 0 loads FFh. This load wins over a firmware-hub write in the same cycle.
- R4: A write with `cfg_sel`=0 stores `cfg_wdata` into the I/O word. A write with `cfg_sel`=1 stores `cfg_wdata[7:0]` into the firmware-hub byte. The stored value reaches `cfg_rdata` and the decode at the clock edge that accepts the write, not before. `cfg_rdata` shows {8'h00, byte} when `cfg_sel`=1.
- R5: The single-port I/O groups are as follows. Bit 12 enables ports 4Eh and 4Fh. Bit 11 enables 2Eh and 2Fh. Bit 10 enables 62h and 66h. Bit 8 enables 60h and 64h.
- R6: The I/O range groups are as follows. Bit 7 enables 200h–20Fh. Bit 6 enables 388h–38Bh. Bit 9 enables 530h–537h. Bit 5 enables 330h–331h. Bit 4 enables 220h–233h. Bit 3 enables 3F0h–3F5h and 3F7h. Bit 2 enables 378h–37Fh. Bit 1 enables 2F8h–2FFh. Bit 0 enables 3F8h–3FFh.
- R7: `fwd_lpc` is asserted only for I/O cycles (`cyc_is_mem`=0). It uses `cyc_addr[15:0]` only, and bits 31:16 have no effect.
- R8: Firmware-hub bit 7 forwards memory FFF80000h–FFFFFFFFh and FFB80000h–FFBFFFFFh.
- R9: Firmware-hub bit 6 forwards memory FFF00000h–FFF7FFFFh and FFB00000h–FFB7FFFFh. Bits 5:0 have no decode effect.
- R10: When firmware-hub bit 7 is set, a memory cycle at 000E0000h–000FFFFFh is forwarded with `shadow_hit`=1 and `xlat_addr` = address + FFF00000h. For every other cycle, `shadow_hit`=0 and `xlat_addr` equals `cyc_addr`.
- R11: `fwd_fwh` is asserted only for memory cycles (`cyc_is_mem`=1).
- R12: The decode outputs follow the address and the cycle flag within the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; its rise samples the strap |
| strap_in | input | 1 | Strap: 1 means no firmware hub present |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the I/O word, 1 selects the firmware-hub byte |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read-back of the selected register |
| cyc_is_mem | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| cyc_addr | input | 32 | Cycle address |
| fwd_lpc | output | 1 | I/O cycle is forwarded to the side bus |
| fwd_fwh | output | 1 | Memory cycle is forwarded to the firmware hub |
| shadow_hit | output | 1 | Memory cycle hit the low shadow window |
| xlat_addr | output | 32 | Translated address |

## Verification
Decode results have zero latency. The bench changes the address and cycle flag, then samples the outputs one nanosecond later, before any clock edge can matter. Register effects have one-cycle latency. Writes and power-good rises are driven on a falling edge and checked on the next falling edge, after exactly one rising edge. The same-cycle ordering is probed as well: the decode is read before that edge and must still show the old value. Reset release goes through a two-stage synchronizer, so the bench waits several cycles before checking the reset values.

// File: rtl/lpcdec_pkg.sv
package lpcdec_pkg;
  localparam int IO_AW     = 16;
  localparam int NUM_IO_EN = 13;
  localparam int FWH_W     = 8;
  localparam int MEM_AW    = 32;

  typedef struct packed {
    logic [IO_AW-1:0] lo;
    logic [IO_AW-1:0] hi;
  } io_win_t;

  localparam io_win_t NO_WIN = '{lo: 16'hFFFF, hi: 16'h0000};

  function automatic io_win_t mk(input logic [15:0] lo, input logic [15:0] hi);
    io_win_t w;
    w.lo = lo;
    w.hi = hi;
    return w;
  endfunction

  // Each enable bit owns up to two inclusive port windows.
  function automatic io_win_t io_win(input int idx, input int part);
    io_win_t w;
    w = NO_WIN;
    case (idx)
      0:  if (part == 0) w = mk(16'h03F8, 16'h03FF);
      1:  if (part == 0) w = mk(16'h02F8, 16'h02FF);
      2:  if (part == 0) w = mk(16'h0378, 16'h037F);
      3:  w = (part == 0) ? mk(16'h03F0, 16'h03F5) : mk(16'h03F7, 16'h03F7);
      4:  if (part == 0) w = mk(16'h0220, 16'h0233);
      5:  if (part == 0) w = mk(16'h0330, 16'h0331);
      6:  if (part == 0) w = mk(16'h0388, 16'h038B);
      7:  if (part == 0) w = mk(16'h0200, 16'h020F);
      8:  w = (part == 0) ? mk(16'h0060, 16'h0060) : mk(16'h0064, 16'h0064);
      9:  if (part == 0) w = mk(16'h0530, 16'h0537);
      10: w = (part == 0) ? mk(16'h0062, 16'h0062) : mk(16'h0066, 16'h0066);
      11: if (part == 0) w = mk(16'h002E, 16'h002F);
      12: if (part == 0) w = mk(16'h004E, 16'h004F);
      default: w = NO_WIN;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/lpcdec_regs.sv
module lpcdec_regs
  import lpcdec_pkg::*;
#(
  parameter int IO_W   = IO_AW,
  parameter int LIVE_W = NUM_IO_EN,
  parameter int HUB_W  = FWH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              strap_in,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IO_W-1:0]   cfg_wdata,
  output logic [IO_W-1:0]   io_en,
  output logic [HUB_W-1:0]  hub_en
);
  localparam logic [IO_W-1:0] LIVE_MASK = IO_W'((1 << LIVE_W) - 1);

  logic              pg_q;
  logic              pg_rise;
  logic [IO_W-1:0]   io_q, io_nx;
  logic [HUB_W-1:0]  hub_q, hub_nx;
  logic              io_ce, hub_ce;

  assign pg_rise = pwr_good & ~pg_q;

  always_comb begin
    io_ce  = cfg_we & ~cfg_sel;
    hub_ce = (cfg_we & cfg_sel) | pg_rise;
    io_nx  = cfg_wdata & LIVE_MASK;
    if (pg_rise) hub_nx = strap_in ? '0 : '1;
    else         hub_nx = cfg_wdata[HUB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q  <= 1'b0;
      io_q  <= '0;
      hub_q <= '0;
    end else begin
      pg_q <= pwr_good;
      if (io_ce)  io_q  <= io_nx;
      if (hub_ce) hub_q <= hub_nx;
    end
  end

  assign io_en  = io_q;
  assign hub_en = hub_q;

  AST_IO_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    io_q[IO_W-1:LIVE_W] == '0); // R2
  AST_STRAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !pg_q) |=> (hub_q == ($past(strap_in) ? {HUB_W{1'b0}} : {HUB_W{1'b1}}))); // R3
  AST_IO_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (io_q == ($past(cfg_wdata) & LIVE_MASK))); // R4
endmodule

// File: rtl/lpcdec_io_match.sv
module lpcdec_io_match
  import lpcdec_pkg::*;
#(
  parameter int NWIN = NUM_IO_EN,
  parameter int AW   = IO_AW
) (
  input  logic            is_mem,
  input  logic [AW-1:0]   port,
  input  logic [NWIN-1:0] en,
  output logic            hit
);
  logic [NWIN-1:0] win_hit;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    localparam io_win_t W0 = io_win(i, 0);
    localparam io_win_t W1 = io_win(i, 1);
    logic in0, in1;
    assign in0 = (port >= W0.lo) && (port <= W0.hi);
    assign in1 = (port >= W1.lo) && (port <= W1.hi);
    assign win_hit[i] = en[i] & (in0 | in1);
  end

  assign hit = ~is_mem & (|win_hit);
endmodule

// File: rtl/lpcdec_mem_match.sv
module lpcdec_mem_match
  import lpcdec_pkg::*;
#(
  parameter int AW     = MEM_AW,
  parameter int BLK_AW = 19,
  parameter int SHD_AW = 17
) (
  input  logic          is_mem,
  input  logic [AW-1:0] addr,
  input  logic          en_hi,
  input  logic          en_lo,
  output logic          hit,
  output logic          shadow,
  output logic [AW-1:0] xlat
);
  localparam int TAG_W = AW - BLK_AW;
  localparam int SHT_W = AW - SHD_AW;
  localparam logic [TAG_W-1:0] TOP_TAG   = '1;
  localparam logic [TAG_W-1:0] TOP_TAG_1 = TOP_TAG - TAG_W'(1);
  localparam logic [TAG_W-1:0] REG_TAG   = TOP_TAG - TAG_W'(8);
  localparam logic [TAG_W-1:0] REG_TAG_1 = TOP_TAG - TAG_W'(9);
  localparam logic [SHT_W-1:0] LOW_SHT   = SHT_W'(7);

  logic [TAG_W-1:0] tag;
  logic hi_blk, lo_blk;

  assign tag    = addr[AW-1:BLK_AW];
  assign hi_blk = en_hi & ((tag == TOP_TAG)   | (tag == REG_TAG));
  assign lo_blk = en_lo & ((tag == TOP_TAG_1) | (tag == REG_TAG_1));
  assign shadow = is_mem & en_hi & (addr[AW-1:SHD_AW] == LOW_SHT);
  assign hit    = is_mem & (hi_blk | lo_blk | shadow);
  assign xlat   = shadow ? {{SHT_W{1'b1}}, addr[SHD_AW-1:0]} : addr;
endmodule

// File: rtl/lpc_fwh_decoder.sv
module lpc_fwh_decoder
  import lpcdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              strap_in,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IO_AW-1:0]  cfg_wdata,
  output logic [IO_AW-1:0]  cfg_rdata,
  input  logic              cyc_is_mem,
  input  logic [MEM_AW-1:0] cyc_addr,
  output logic              fwd_lpc,
  output logic              fwd_fwh,
  output logic              shadow_hit,
  output logic [MEM_AW-1:0] xlat_addr
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  logic [IO_AW-1:0] io_en;
  logic [FWH_W-1:0] hub_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  lpcdec_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .pwr_good(pwr_good), .strap_in(strap_in),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .io_en(io_en), .hub_en(hub_en)
  );

  lpcdec_io_match u_io (
    .is_mem(cyc_is_mem), .port(cyc_addr[IO_AW-1:0]),
    .en(io_en[NUM_IO_EN-1:0]), .hit(fwd_lpc)
  );

  lpcdec_mem_match u_mem (
    .is_mem(cyc_is_mem), .addr(cyc_addr), .en_hi(hub_en[7]), .en_lo(hub_en[6]),
    .hit(fwd_fwh), .shadow(shadow_hit), .xlat(xlat_addr)
  );

  assign cfg_rdata = cfg_sel ? {{(IO_AW-FWH_W){1'b0}}, hub_en} : io_en;

  AST_LPC_IO_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    fwd_lpc |-> !cyc_is_mem); // R7
  AST_FWH_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_int_n)
    fwd_fwh |-> cyc_is_mem); // R11
  AST_SHADOW_XLAT: assert property (@(posedge clk) disable iff (!rst_int_n)
    shadow_hit |-> (fwd_fwh && xlat_addr[31:17] == 15'h7FFF)); // R10
  AST_SHADOW_NEEDS_F8: assert property (@(posedge clk) disable iff (!rst_int_n)
    shadow_hit |-> hub_en[7]); // R10
  AST_NO_SHADOW_PASS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !shadow_hit |-> (xlat_addr == cyc_addr)); // R10
endmodule

// File: tb/sim_lpc_fwh_decoder.sv
`timescale 1ns/1ps
module sim_lpc_fwh_decoder;
  logic        clk = 1'b0;
  logic        rst_n, pwr_good, strap_in, cfg_we, cfg_sel, cyc_is_mem;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic [31:0] cyc_addr, xlat_addr;
  logic        fwd_lpc, fwd_fwh, shadow_hit;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  lpc_fwh_decoder u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_io(input logic [15:0] en, input logic [15:0] a);
    logic h;
    h = 1'b0;
    h |= en[12] && (a == 16'h4E || a == 16'h4F);
    h |= en[11] && (a == 16'h2E || a == 16'h2F);
    h |= en[10] && (a == 16'h62 || a == 16'h66);
    h |= en[8]  && (a == 16'h60 || a == 16'h64);
    h |= en[7]  && (a >= 16'h200 && a <= 16'h20F);
    h |= en[6]  && (a >= 16'h388 && a <= 16'h38B);
    h |= en[9]  && (a >= 16'h530 && a <= 16'h537);
    h |= en[5]  && (a >= 16'h330 && a <= 16'h331);
    h |= en[4]  && (a >= 16'h220 && a <= 16'h233);
    h |= en[3]  && ((a >= 16'h3F0 && a <= 16'h3F5) || a == 16'h3F7);
    h |= en[2]  && (a >= 16'h378 && a <= 16'h37F);
    h |= en[1]  && (a >= 16'h2F8 && a <= 16'h2FF);
    h |= en[0]  && (a >= 16'h3F8 && a <= 16'h3FF);
    return h;
  endfunction

  task automatic wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic io_sweep(input logic [15:0] en);
    wr(1'b0, en);
    cyc_is_mem = 1'b0;
    for (int a = 0; a < 4096; a++) begin
      cyc_addr = {16'(a * 16'h9E37 + 16'h1234), 16'(a)};
      #1;
      chk(fwd_lpc == exp_io(en, 16'(a)), "R5/R6/R7 io decode", {31'b0, fwd_lpc}, {31'b0, exp_io(en, 16'(a))});
      chk(fwd_fwh == 1'b0, "R11 no hub on io", {31'b0, fwd_fwh}, 32'd0);
    end
  endtask

  task automatic mem_sweep(input logic [7:0] en);
    logic f8, f0, sh, hit;
    logic [31:0] a, xl;
    wr(1'b1, {8'h00, en});
    cyc_is_mem = 1'b1;
    for (int hi = 0; hi < 65536; hi++) begin
      for (int k = 0; k < 2; k++) begin
        a = {16'(hi), (k == 0) ? 16'h0000 : 16'hFFFF};
        cyc_addr = a;
        f8  = en[7] && ((a >= 32'hFFF80000) || (a >= 32'hFFB80000 && a <= 32'hFFBFFFFF));
        f0  = en[6] && ((a >= 32'hFFF00000 && a <= 32'hFFF7FFFF) || (a >= 32'hFFB00000 && a <= 32'hFFB7FFFF));
        sh  = en[7] && (a >= 32'h000E0000 && a <= 32'h000FFFFF);
        hit = f8 | f0 | sh;
        xl  = sh ? a + 32'hFFF00000 : a;
        #1;
        chk(fwd_fwh == hit, "R8/R9 hub decode", {31'b0, fwd_fwh}, {31'b0, hit});
        chk(shadow_hit == sh && xlat_addr == xl, "R10 shadow/xlat", xlat_addr, xl);
        chk(fwd_lpc == 1'b0, "R7 no io on mem", {31'b0, fwd_lpc}, 32'd0);
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      chk(1'b0, "watchdog", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwr_good = 1'b0; strap_in = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0;
    cfg_wdata = '0; cyc_is_mem = 1'b0; cyc_addr = 32'h0000_03F8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset values and no forwarding
    cfg_sel = 1'b0; #1;
    chk(cfg_rdata == 16'h0000, "R1 io word reset", {16'b0, cfg_rdata}, 32'h0);
    cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 16'h0000, "R1 hub byte reset", {16'b0, cfg_rdata}, 32'h0);
    chk(fwd_lpc == 1'b0, "R1 no io forward", {31'b0, fwd_lpc}, 32'h0);
    cyc_is_mem = 1'b1; cyc_addr = 32'hFFFF_FFF0; #1;
    chk(fwd_fwh == 1'b0, "R1 no hub forward", {31'b0, fwd_fwh}, 32'h0);

    // R3: strap 0 loads all ones
    @(negedge clk); strap_in = 1'b0; pwr_good = 1'b1;
    @(negedge clk); cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 16'h00FF, "R3 strap0 -> FF", {16'b0, cfg_rdata}, 32'hFF);
    // R3: strap 1 loads zero and beats a same-cycle write
    pwr_good = 1'b0;
    @(negedge clk); strap_in = 1'b1; pwr_good = 1'b1;
    cfg_sel = 1'b1; cfg_wdata = 16'h00C3; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0; #1;
    chk(cfg_rdata == 16'h0000, "R3 strap1 -> 00 over write", {16'b0, cfg_rdata}, 32'h0);

    // R2: reserved bits
    wr(1'b0, 16'hFFFF); cfg_sel = 1'b0; #1;
    chk(cfg_rdata == 16'h1FFF, "R2 reserved read zero", {16'b0, cfg_rdata}, 32'h1FFF);
    // R4 / R12: write visible only after the accepting edge
    wr(1'b0, 16'h0000);
    cyc_is_mem = 1'b0; cyc_addr = 32'h0000_002E;
    @(negedge clk); cfg_sel = 1'b0; cfg_wdata = 16'h0800; cfg_we = 1'b1; #1;
    chk(fwd_lpc == 1'b0, "R4 not before edge", {31'b0, fwd_lpc}, 32'h0);
    @(negedge clk); cfg_we = 1'b0; #1;
    chk(fwd_lpc == 1'b1, "R4 after edge", {31'b0, fwd_lpc}, 32'h1);
    chk(cfg_rdata == 16'h0800, "R4 io readback", {16'b0, cfg_rdata}, 32'h800);
    cyc_addr = 32'h0000_002F; #1;
    chk(fwd_lpc == 1'b1, "R12 same-cycle follow", {31'b0, fwd_lpc}, 32'h1);
    cyc_is_mem = 1'b1; #1;
    chk(fwd_lpc == 1'b0, "R7 mem flag blocks io", {31'b0, fwd_lpc}, 32'h0);
    wr(1'b1, 16'hAB5A); cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 16'h005A, "R4 hub readback", {16'b0, cfg_rdata}, 32'h5A);

    // Exhaustive I/O sweeps
    wr(1'b1, 16'h0000);
    io_sweep(16'h0000);
    for (int b = 0; b < 13; b++) io_sweep(16'(1 << b));
    io_sweep(16'h1FFF);
    wr(1'b0, 16'h0000);

    // Memory sweeps, R9 includes bits 5:0 having no effect
    mem_sweep(8'h00);
    mem_sweep(8'h3F);
    mem_sweep(8'h80);
    mem_sweep(8'h40);
    mem_sweep(8'hC0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule